// File: doc/BRIEF.md
# Triple-Copy Memory Sequencer with Scrub-Back

This block sits between a bus master and a single 16-bit memory and makes that memory behave as three redundant stores. The master sees one word-wide port: it issues a read or a write for a logical address and waits while `busy` is high. Internally every logical word has three physical copies, held in three separate address regions of the one memory. Because there is only one memory, every access to the copies is made one after the other.

A write stores the word into all three copies in turn. A read fetches the three copies in turn, forms a bitwise majority of them, and returns the majority word together with a mask of the copies that disagreed with it. Each disagreeing copy is then overwritten with the majority word, so a single upset is repaired before the next access. A counter records how many reads found at least one bad copy. The majority stage has a parameterised pipeline depth. The memory is reached through a simple request/done handshake, and its response latency is set by the memory, not by this block.

Top module: `tmr_mem_seq`

## Requirements
- R1: While and after a synchronous reset, `busy`, `rsp_valid` and `mem_req` are low and `error_count` is zero.
- R2: A write issues exactly three memory writes of `req_wdata`, to copies 0, 1 and 2 in that order. Copy k of logical address A is at physical address {k[1:0], A}, with the copy index in the two most significant bits of `mem_addr`.
- R3: A read issues three memory reads, to copies 0, 1 and 2 in that order. It then returns on `rsp_rdata` the bitwise majority (a&b)|(a&c)|(b&c) of the three values, with one single-cycle `rsp_valid` pulse.
- R4: `rsp_valid` rises VOTE_LAT+1 clock cycles after the cycle in which `mem_done` presents the third copy's read data.
- R5: During the `rsp_valid` cycle, bit k of `rsp_fixed` is 1 exactly when copy k differs from the returned majority word.
- R6: After the response, each copy flagged in `rsp_fixed` is written with the majority word, in ascending copy order. No copy that agreed with the majority is written.
- R7: `error_count` increases by one, modulo 2^CNT_W, for each read with a nonzero `rsp_fixed`. It does not change otherwise.
- R8: `busy` rises in the cycle after a request is taken and stays high until the last memory access of that operation (including scrub writes) has completed. A request presented while `busy` is high is ignored: it causes no memory access and changes no stored copy.
- R9: At most one memory request is outstanding: `mem_req` is not asserted again until `mem_done` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Logical word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Operation in progress; requests ignored |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 16 | Majority-voted read word |
| rsp_fixed | output | 3 | Copies that disagreed with the vote |
| error_count | output | CNT_W | Reads that found at least one bad copy |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W+2 | Physical address {copy, logical address} |
| mem_wdata | output | 16 | Memory write data |
| mem_done | input | 1 | Memory completion pulse |
| mem_rdata | input | 16 | Memory read data, valid with `mem_done` |

## Verification
The hardest case to reach from the ports is a read in which the stored copies disagree, because the block's own writes always leave the three copies equal. The testbench owns the memory model, so between operations it flips chosen bits in one, two or all three copies of an address. This produces single-copy faults, two copies bad in different bits (the majority still rebuilds the word), and every copy bad in a distinct bit (all three get rewritten). It then checks the voted word, the mask, the exact set and order of scrub writes, and the repaired memory contents.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int DATA_W   = 16;
    localparam int N_COPIES = 3;
    localparam int COPY_W   = 2;

    typedef logic [DATA_W-1:0]   word_t;
    typedef logic [N_COPIES-1:0] copy_mask_t;
    typedef logic [COPY_W-1:0]   copy_idx_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_VOTE,
        ST_RESP,
        ST_SCRUB_ISSUE,
        ST_SCRUB_WAIT
    } seq_state_e;

    typedef struct packed {
        word_t      voted;
        copy_mask_t diff;
    } vote_t;

    typedef struct packed {
        logic  we;
        word_t wdata;
    } op_t;

    function automatic word_t maj3(word_t a, word_t b, word_t c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic copy_idx_t first_copy(copy_mask_t m);
        if (m[0])      return copy_idx_t'(0);
        else if (m[1]) return copy_idx_t'(1);
        else           return copy_idx_t'(2);
    endfunction

endpackage

// File: rtl/tmr_voter.sv
module tmr_voter
    import tmr_pkg::*;
#(
    parameter int LAT = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  word_t cp_a,
    input  word_t cp_b,
    input  word_t cp_c,
    output logic  out_valid,
    output vote_t out_res
);

    vote_t comb_res;

    always_comb begin
        comb_res.voted   = maj3(cp_a, cp_b, cp_c);
        comb_res.diff[0] = (cp_a != comb_res.voted);
        comb_res.diff[1] = (cp_b != comb_res.voted);
        comb_res.diff[2] = (cp_c != comb_res.voted);
    end

    generate
        if (LAT == 0) begin : g_direct
            assign out_valid = in_valid;
            assign out_res   = comb_res;
        end else begin : g_pipe
            vote_t          pipe_q [LAT];
            logic [LAT-1:0] vld_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= '0;
                end else begin
                    for (int i = LAT - 1; i > 0; i--) begin
                        vld_q[i] <= vld_q[i-1];
                    end
                    vld_q[0] <= in_valid;
                end
            end

            always_ff @(posedge clk) begin
                for (int i = LAT - 1; i > 0; i--) begin
                    pipe_q[i] <= pipe_q[i-1];
                end
                pipe_q[0] <= comb_res;
            end

            assign out_valid = vld_q[LAT-1];
            assign out_res   = pipe_q[LAT-1];

            // R4
            vote_pulse_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid |=> !out_valid)
                else $error("voter valid lasted more than one cycle");
        end
    endgenerate

endmodule

// File: rtl/tmr_err_counter.sv
module tmr_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (bump) begin
            count <= count + CNT_W'(1);
        end
    end

    // R7
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)))
        else $error("error counter moved by other than one");

endmodule

// File: rtl/tmr_mem_seq.sv
module tmr_mem_seq
    import tmr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int VOTE_LAT = 1,
    parameter int CNT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [N_COPIES-1:0]  rsp_fixed,
    output logic [CNT_W-1:0]     error_count,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W+1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic                 mem_done,
    input  logic [DATA_W-1:0]    mem_rdata
);

    localparam int PADDR_W = ADDR_W + COPY_W;
    localparam copy_idx_t LAST_COPY = copy_idx_t'(N_COPIES - 1);

    seq_state_e        state_q;
    copy_idx_t         copy_q;
    op_t               op_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             slot_q [N_COPIES-1];
    vote_t             vote_q;
    copy_mask_t        fix_left_q;
    logic              outstanding_q;

    logic   start_vote;
    logic   vote_valid;
    vote_t  vote_res;
    logic   err_bump;

    assign start_vote = (state_q == ST_WAIT) && mem_done && !op_q.we && (copy_q == LAST_COPY);

    tmr_voter #(.LAT(VOTE_LAT)) i_voter (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (start_vote),
        .cp_a      (slot_q[0]),
        .cp_b      (slot_q[1]),
        .cp_c      (mem_rdata),
        .out_valid (vote_valid),
        .out_res   (vote_res)
    );

    assign err_bump = (state_q == ST_VOTE) && vote_valid && (vote_res.diff != '0);

    tmr_err_counter #(.CNT_W(CNT_W)) i_err_counter (
        .clk   (clk),
        .rst   (rst),
        .bump  (err_bump),
        .count (error_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            copy_q     <= '0;
            op_q       <= '0;
            addr_q     <= '0;
            vote_q     <= '0;
            fix_left_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q.we    <= req_we;
                        op_q.wdata <= req_wdata;
                        addr_q     <= req_addr;
                        copy_q     <= '0;
                        state_q    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_done) begin
                        if (copy_q == LAST_COPY) begin
                            state_q <= op_q.we ? ST_IDLE : ST_VOTE;
                        end else begin
                            copy_q  <= copy_q + copy_idx_t'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_VOTE: begin
                    if (vote_valid) begin
                        vote_q     <= vote_res;
                        fix_left_q <= vote_res.diff;
                        state_q    <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (fix_left_q != '0) begin
                        copy_q  <= first_copy(fix_left_q);
                        state_q <= ST_SCRUB_ISSUE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_SCRUB_ISSUE: begin
                    fix_left_q[copy_q] <= 1'b0;
                    state_q            <= ST_SCRUB_WAIT;
                end
                ST_SCRUB_WAIT: begin
                    if (mem_done) begin
                        if (fix_left_q != '0) begin
                            copy_q  <= first_copy(fix_left_q);
                            state_q <= ST_SCRUB_ISSUE;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // read data of the first two copies is held until the third arrives
    always_ff @(posedge clk) begin
        if (state_q == ST_WAIT && mem_done && !op_q.we && copy_q != LAST_COPY) begin
            slot_q[copy_q[0]] <= mem_rdata;
        end
    end

    // tracks the handshake with memory, used only by the check below
    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
        end else if (mem_req) begin
            outstanding_q <= 1'b1;
        end else if (mem_done) begin
            outstanding_q <= 1'b0;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_rdata = vote_q.voted;
    assign rsp_fixed = vote_q.diff;

    assign mem_req   = (state_q == ST_ISSUE) || (state_q == ST_SCRUB_ISSUE);
    assign mem_we    = (state_q == ST_SCRUB_ISSUE) ? 1'b1 : op_q.we;
    assign mem_addr  = PADDR_W'({copy_q, addr_q});
    assign mem_wdata = (state_q == ST_SCRUB_ISSUE) ? vote_q.voted : op_q.wdata;

    // R9
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !outstanding_q)
        else $error("memory request issued while one is pending");

    // R2
    copy_range_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[PADDR_W-1 -: COPY_W] != copy_idx_t'(3)))
        else $error("copy index out of range");

    // R6
    scrub_data_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && state_q == ST_SCRUB_ISSUE) |-> (mem_we && mem_wdata == rsp_rdata && rsp_fixed[copy_q]))
        else $error("scrub write does not carry the voted word to a flagged copy");

    // R7
    err_on_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (error_count != $past(error_count)) |-> (rsp_valid && rsp_fixed != '0))
        else $error("error count changed outside a faulty response");

    // R8
    busy_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid))
        else $error("busy rose without a request");

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid)
        else $error("response lasted more than one cycle");

endmodule

// File: tb/test_tmr_mem_seq.sv
module test_tmr_mem_seq;

    localparam int ADDR_W   = 6;
    localparam int VOTE_LAT = 2;
    localparam int CNT_W    = 8;
    localparam int BL       = 1;
    localparam int MEM_LAT  = 4 + BL;
    localparam int WORDS    = 4 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_we = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       req_wdata = '0;
    logic              busy, rsp_valid;
    logic [15:0]       rsp_rdata;
    logic [2:0]        rsp_fixed;
    logic [CNT_W-1:0]  error_count;
    logic              mem_req, mem_we;
    logic [ADDR_W+1:0] mem_addr;
    logic [15:0]       mem_wdata;
    logic              mem_done = 1'b0;
    logic [15:0]       mem_rdata = '0;

    always #2.5 clk = ~clk;

    tmr_mem_seq #(.ADDR_W(ADDR_W), .VOTE_LAT(VOTE_LAT), .CNT_W(CNT_W)) i_tmr_mem_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fixed(rsp_fixed),
        .error_count(error_count), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_done(mem_done),
        .mem_rdata(mem_rdata)
    );

    // memory model
    logic [15:0]       mem_arr [WORDS];
    logic              pend = 1'b0;
    int                cnt = 0;
    logic              m_we = 1'b0;
    logic [ADDR_W+1:0] m_addr = '0;
    logic [15:0]       m_wdata = '0;
    int                lg_n = 0;
    int                lg_copy [16];
    logic              lg_we [16];
    logic [15:0]       lg_data [16];

    always @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            mem_done <= 1'b0;
        end else begin
            mem_done <= 1'b0;
            if (mem_req) begin
                pend    <= 1'b1;
                cnt     <= MEM_LAT;
                m_we    <= mem_we;
                m_addr  <= mem_addr;
                m_wdata <= mem_wdata;
                if (lg_n < 16) begin
                    lg_copy[lg_n] = int'(mem_addr[ADDR_W+1:ADDR_W]);
                    lg_we[lg_n]   = mem_we;
                    lg_data[lg_n] = mem_wdata;
                end
                lg_n = lg_n + 1;
            end else if (pend) begin
                if (cnt == 1) begin
                    mem_done <= 1'b1;
                    pend     <= 1'b0;
                    if (m_we) mem_arr[m_addr] = m_wdata;
                    else      mem_rdata <= mem_arr[m_addr];
                end else begin
                    cnt <= cnt - 1;
                end
            end
        end
    end

    // cycle counter and negedge monitor
    int          cyc = 0;
    int          last_rd_done = 0;
    int          rsp_cyc = 0;
    int          got_rsp = 0;
    logic [15:0] cap_data = '0;
    logic [2:0]  cap_fix = '0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (mem_done && !m_we) last_rd_done = cyc;
        if (rsp_valid) begin
            got_rsp  = got_rsp + 1;
            rsp_cyc  = cyc;
            cap_data = rsp_rdata;
            cap_fix  = rsp_fixed;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    logic [CNT_W-1:0] exp_err = '0;

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] maj(logic [15:0] a, logic [15:0] b, logic [15:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic [ADDR_W+1:0] pa(int k, logic [ADDR_W-1:0] a);
        return {k[1:0], a};
    endfunction

    task automatic issue(input logic we, input logic [ADDR_W-1:0] a, input logic [15:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        lg_n = 0;
        got_rsp = 0;
        req_valid = 1'b1;
        req_we = we;
        req_addr = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic finish_op();
        while (busy) @(negedge clk);
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        issue(1'b1, a, d);
        finish_op();
        // R2: three writes, copies 0,1,2 in order, data everywhere
        check(lg_n == 3, "R2 write count", lg_n, 3);
        for (int k = 0; k < 3; k++) begin
            check(lg_we[k] && lg_copy[k] == k && lg_data[k] == d, "R2 write order", lg_copy[k], k);
            check(mem_arr[pa(k, a)] == d, "R2 copy content", mem_arr[pa(k, a)], d);
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a);
        logic [15:0] c0, c1, c2, ev;
        logic [2:0]  em;
        int          wi;
        c0 = mem_arr[pa(0, a)];
        c1 = mem_arr[pa(1, a)];
        c2 = mem_arr[pa(2, a)];
        ev = maj(c0, c1, c2);
        em = {c2 != ev, c1 != ev, c0 != ev};
        if (em != 3'b000) exp_err = exp_err + CNT_W'(1);
        issue(1'b0, a, 16'h0);
        finish_op();
        // R3
        check(got_rsp == 1, "R3 response count", got_rsp, 1);
        check(cap_data == ev, "R3 voted data", cap_data, ev);
        for (int k = 0; k < 3; k++)
            check(!lg_we[k] && lg_copy[k] == k, "R3 read order", lg_copy[k], k);
        // R4
        check(rsp_cyc - last_rd_done == VOTE_LAT + 1, "R4 vote latency", rsp_cyc - last_rd_done, VOTE_LAT + 1);
        // R5
        check(cap_fix == em, "R5 mismatch mask", cap_fix, em);
        // R6: exactly flagged copies written, ascending, voted data
        check(lg_n == 3 + $countones(em), "R6 scrub count", lg_n, 3 + $countones(em));
        wi = 3;
        for (int k = 0; k < 3; k++) begin
            if (em[k] && wi < 16) begin
                check(lg_we[wi] && lg_copy[wi] == k && lg_data[wi] == ev, "R6 scrub target", lg_copy[wi], k);
                wi++;
            end
            check(mem_arr[pa(k, a)] == ev, "R6 repaired copy", mem_arr[pa(k, a)], ev);
        end
        // R7
        check(error_count == exp_err, "R7 error count", error_count, exp_err);
    endtask

    task automatic corrupt(input int k, input logic [ADDR_W-1:0] a, input logic [15:0] flip);
        mem_arr[pa(k, a)] = mem_arr[pa(k, a)] ^ flip;
    endtask

    initial begin
        for (int i = 0; i < WORDS; i++) mem_arr[i] = 16'h0;
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !rsp_valid && !mem_req && error_count == '0, "R1 during reset",
              {busy, rsp_valid, mem_req}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !rsp_valid && !mem_req && error_count == '0, "R1 after reset",
              {busy, rsp_valid, mem_req}, 0);

        // directed
        do_write(6'd5, 16'hA5C3);
        do_read(6'd5);                       // clean
        corrupt(0, 6'd5, 16'h0001); do_read(6'd5);
        corrupt(1, 6'd5, 16'h8000); do_read(6'd5);
        corrupt(2, 6'd5, 16'hFFFF); do_read(6'd5);
        corrupt(0, 6'd5, 16'h0001); corrupt(1, 6'd5, 16'h0002); do_read(6'd5);
        corrupt(0, 6'd5, 16'h0010); corrupt(1, 6'd5, 16'h0100); corrupt(2, 6'd5, 16'h1000);
        do_read(6'd5);
        do_write(6'd63, 16'hFFFF);
        do_write(6'd0, 16'h0000);
        corrupt(1, 6'd0, 16'h00F0); corrupt(2, 6'd0, 16'h00F0); do_read(6'd0);

        // R8: requests while busy are ignored
        do_write(6'd9, 16'h1234);
        do_write(6'd10, 16'h5555);
        issue(1'b0, 6'd9, 16'h0);
        check(busy, "R8 busy after accept", busy, 1);
        for (int i = 0; i < 4; i++) begin
            req_valid = 1'b1; req_we = 1'b1; req_addr = 6'd10; req_wdata = 16'hDEAD;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(busy, "R8 still busy", busy, 1);
        finish_op();
        check(lg_n == 3, "R8 no extra access", lg_n, 3);
        for (int k = 0; k < 3; k++)
            check(mem_arr[pa(k, 6'd10)] == 16'h5555, "R8 copy untouched", mem_arr[pa(k, 6'd10)], 16'h5555);
        check(got_rsp == 1 && cap_data == 16'h1234, "R8 read unaffected", cap_data, 16'h1234);

        // random mix
        for (int n = 0; n < 120; n++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'($urandom % (1 << ADDR_W));
            if ($urandom % 3 == 0) begin
                do_write(a, 16'($urandom));
            end else begin
                for (int k = 0; k < 3; k++)
                    if ($urandom % 3 == 0) corrupt(k, a, 16'($urandom));
                do_read(a);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule